// File: doc/BRIEF.md
# Processor-Memory Crossbar With Hold Arbitration

This block joins N processor request ports to N memory module ports through a full grid of crosspoints, one per processor/module pair. Each processor names a target module with an index. Processors whose targets are all different are connected in the same cycle, so traffic to separate modules runs fully in parallel. The only place where requests can conflict is at a module.

When two or more processors want the same module in the same cycle, a round-robin arbiter for that module connects one of them. The others see their grant low and stall. A processor may hold a module across a multi-beat access by raising a lock signal. The arbiter keeps the module with that owner until a beat arrives with the lock low. The module is then released on the following cycle. Read data coming back from a module is steered to the processor that issued the read.

Top module: `pm_xbar`

## Requirements
- R1: After synchronous reset, with no requests, every grant, every read-valid and every module enable is low.
- R2: When valid processors all target different modules, every one of them is granted in the same cycle. Each targeted module port shows its own processor's write flag, address and data in that cycle.
- R3: At most one processor targeting a given module is granted in any cycle.
- R4: Each module has a rotation pointer, which reset sets to 0. A free module grants the first requester found by searching upward from the pointer, with wraparound. After each new grant the pointer moves to the winner's index plus one. A deferred requester is therefore served before the previous winner can win again.
- R5: While the owner of a module keeps requesting it with lock high (lock is bit `req_lock[p]`), it stays granted every cycle, whatever the other requests are. The beat with lock low is still granted. The module becomes free for arbitration on the next cycle.
- R6: A processor that loses arbitration sees its grant low, and its fields do not reach the module port.
- R7: When a read (write flag 0) is granted in cycle t, `rsp_valid` of that processor alone is high in cycle t+1. Its `rsp_data` carries the word the module returned.
- R8: A granted write (write flag 1) drives the module's enable and write flag high with the processor's address and data, and produces no read-valid on the next cycle.
- R9: A processor whose `req_valid` is low is never granted and causes no module access, whatever its other request fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Per-processor request valid |
| req_lock | input | N | Per-processor hold-module request |
| req_we | input | N | Per-processor write flag (1 = write) |
| req_mod | input | N*IW | Per-processor target module index |
| req_addr | input | N*AW | Per-processor word address |
| req_wdata | input | N*DW | Per-processor write data |
| gnt | output | N | Per-processor grant; low means stall |
| rsp_valid | output | N | Per-processor read data valid |
| rsp_data | output | N*DW | Per-processor read data |
| mem_en | output | N | Per-module access enable |
| mem_we | output | N | Per-module write flag |
| mem_addr | output | N*AW | Per-module address |
| mem_wdata | output | N*DW | Per-module write data |
| mem_rdata | input | N*DW | Per-module read data, one cycle after a read enable |

## Verification
A permutation pattern, with every processor aimed at a different module, separates true parallel connection from any serialising of the grid. It also shows whether fields are routed to the right module port and whether read data returns to the right processor. Two-way and three-way contention on one module exposes the rotation order and stall behaviour. A locked multi-beat write with a competitor waiting shows the hold and the exact release cycle. An invalid request carrying a live module index checks that the valid qualifier gates both the grant and the module access.

// File: rtl/pm_xbar_pkg.sv
package pm_xbar_pkg;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    function automatic int unsigned wrap_idx(input int unsigned base,
                                             input int unsigned off,
                                             input int unsigned n);
        return (base + off) % n;
    endfunction

endpackage

// File: rtl/pm_xbar_arb.sv
module pm_xbar_arb
    import pm_xbar_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  lock,
    output logic [N-1:0]  gnt_oh,
    output logic [IW-1:0] win,
    output logic          any_gnt
);

    arb_state_e    state_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;

    always_comb begin
        gnt_oh  = '0;
        win     = '0;
        any_gnt = 1'b0;
        if (state_q == ARB_HELD) begin
            if (req[owner_q]) begin
                gnt_oh[owner_q] = 1'b1;
                win             = owner_q;
                any_gnt         = 1'b1;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (!any_gnt && req[wrap_idx(ptr_q, i, N)]) begin
                    any_gnt                        = 1'b1;
                    win                            = IW'(wrap_idx(ptr_q, i, N));
                    gnt_oh[wrap_idx(ptr_q, i, N)]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_FREE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (any_gnt) begin
            state_q <= lock[win] ? ARB_HELD : ARB_FREE;
            owner_q <= win;
            if (state_q == ARB_FREE)
                ptr_q <= IW'(wrap_idx(win, 1, N));
        end else begin
            state_q <= ARB_FREE;
        end
    end

    // R3: a module never connects two processors at once
    a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_oh));

    // R6: a grant only goes to a requester
    a_r6_grant_has_req: assert property (@(posedge clk) disable iff (rst)
        (gnt_oh & ~req) == '0);

endmodule

// File: rtl/pm_xbar_route.sv
module pm_xbar_route #(
    parameter int N  = 4,
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [N-1:0]         sel_oh,
    input  logic [N-1:0]         we_in,
    input  logic [N-1:0][AW-1:0] addr_in,
    input  logic [N-1:0][DW-1:0] wdata_in,
    output logic                 en_out,
    output logic                 we_out,
    output logic [AW-1:0]        addr_out,
    output logic [DW-1:0]        wdata_out
);

    always_comb begin
        en_out    = |sel_oh;
        we_out    = 1'b0;
        addr_out  = '0;
        wdata_out = '0;
        for (int p = 0; p < N; p++) begin
            we_out    = we_out    | (sel_oh[p] & we_in[p]);
            addr_out  = addr_out  | ({AW{sel_oh[p]}} & addr_in[p]);
            wdata_out = wdata_out | ({DW{sel_oh[p]}} & wdata_in[p]);
        end
    end

endmodule

// File: rtl/pm_xbar_ret.sv
module pm_xbar_ret #(
    parameter int N  = 4,
    parameter int IW = $clog2(N),
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         rd_go,
    input  logic [N-1:0][IW-1:0] rd_src,
    input  logic [N-1:0][DW-1:0] mem_rdata,
    output logic [N-1:0]         rsp_valid,
    output logic [N-1:0][DW-1:0] rsp_data
);

    logic [N-1:0]         pend_q;
    logic [N-1:0][IW-1:0] src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            src_q  <= '0;
        end else begin
            pend_q <= rd_go;
            src_q  <= rd_src;
        end
    end

    always_comb begin
        rsp_valid = '0;
        rsp_data  = '0;
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < N; m++) begin
                if (pend_q[m] && src_q[m] == IW'(p)) begin
                    rsp_valid[p] = 1'b1;
                    rsp_data[p]  = rsp_data[p] | mem_rdata[m];
                end
            end
        end
    end

endmodule

// File: rtl/pm_xbar.sv
module pm_xbar
    import pm_xbar_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req_valid,
    input  logic [N-1:0]         req_lock,
    input  logic [N-1:0]         req_we,
    input  logic [N-1:0][IW-1:0] req_mod,
    input  logic [N-1:0][AW-1:0] req_addr,
    input  logic [N-1:0][DW-1:0] req_wdata,
    output logic [N-1:0]         gnt,
    output logic [N-1:0]         rsp_valid,
    output logic [N-1:0][DW-1:0] rsp_data,
    output logic [N-1:0]         mem_en,
    output logic [N-1:0]         mem_we,
    output logic [N-1:0][AW-1:0] mem_addr,
    output logic [N-1:0][DW-1:0] mem_wdata,
    input  logic [N-1:0][DW-1:0] mem_rdata
);

    logic [N-1:0][N-1:0]  gnt_mat;   // [module][processor]
    logic [N-1:0][IW-1:0] win_idx;
    logic [N-1:0]         mod_busy;
    logic [N-1:0]         rd_go;

    for (genvar m = 0; m < N; m++) begin : g_mod
        logic [N-1:0] want;
        for (genvar p = 0; p < N; p++) begin : g_want
            assign want[p] = req_valid[p] && (req_mod[p] == IW'(m));
        end

        pm_xbar_arb #(.N(N), .IW(IW)) i_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (want),
            .lock    (req_lock),
            .gnt_oh  (gnt_mat[m]),
            .win     (win_idx[m]),
            .any_gnt (mod_busy[m])
        );

        pm_xbar_route #(.N(N), .AW(AW), .DW(DW)) i_route (
            .sel_oh    (gnt_mat[m]),
            .we_in     (req_we),
            .addr_in   (req_addr),
            .wdata_in  (req_wdata),
            .en_out    (mem_en[m]),
            .we_out    (mem_we[m]),
            .addr_out  (mem_addr[m]),
            .wdata_out (mem_wdata[m])
        );

        assign rd_go[m] = mem_en[m] && !mem_we[m];

        // R3: among processors aiming at this module, at most one sees a grant
        logic [N-1:0] port_gnt;
        for (genvar p = 0; p < N; p++) begin : g_pg
            assign port_gnt[p] = gnt[p] && (req_mod[p] == IW'(m));
        end
        a_r3_one_per_module: assert property (@(posedge clk) disable iff (rst)
            $onehot0(port_gnt));
    end

    always_comb begin
        gnt = '0;
        for (int m = 0; m < N; m++)
            gnt = gnt | gnt_mat[m];
    end

    pm_xbar_ret #(.N(N), .IW(IW), .DW(DW)) i_ret (
        .clk       (clk),
        .rst       (rst),
        .rd_go     (rd_go),
        .rd_src    (win_idx),
        .mem_rdata (mem_rdata),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    for (genvar p = 0; p < N; p++) begin : g_chk
        // R9: grants only go to valid requests
        a_r9_gnt_needs_valid: assert property (@(posedge clk) disable iff (rst)
            gnt[p] |-> req_valid[p]);

        // R5: a locked owner that keeps asking for the same module keeps it
        a_r5_lock_keeps: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_lock[p]) |=>
                ((req_valid[p] && req_mod[p] == $past(req_mod[p])) |-> gnt[p]));

        // R7: a granted read returns on the next cycle
        a_r7_read_returns: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && !req_we[p]) |=> rsp_valid[p]);

        // R8: a granted write returns nothing
        a_r8_write_silent: assert property (@(posedge clk) disable iff (rst)
            (gnt[p] && req_we[p]) |=> !rsp_valid[p]);
    end

endmodule

// File: tb/test_pm_xbar.sv
module test_pm_xbar;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;

    logic                 clk = 1'b0;
    logic                 rst;
    logic [N-1:0]         req_valid, req_lock, req_we;
    logic [N-1:0][IW-1:0] req_mod;
    logic [N-1:0][AW-1:0] req_addr;
    logic [N-1:0][DW-1:0] req_wdata;
    logic [N-1:0]         gnt, rsp_valid;
    logic [N-1:0][DW-1:0] rsp_data;
    logic [N-1:0]         mem_en, mem_we;
    logic [N-1:0][AW-1:0] mem_addr;
    logic [N-1:0][DW-1:0] mem_wdata;
    logic [N-1:0][DW-1:0] mem_rdata;

    logic [DW-1:0] bmem [N][256];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_xbar #(.N(N), .AW(AW), .DW(DW)) i_pm_xbar (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_lock(req_lock), .req_we(req_we),
        .req_mod(req_mod), .req_addr(req_addr), .req_wdata(req_wdata),
        .gnt(gnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // behavioural synchronous memories
    initial begin
        for (int m = 0; m < N; m++)
            for (int a = 0; a < 256; a++)
                bmem[m][a] = DW'(m * 4096 + a * 3);
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        for (int m = 0; m < N; m++) begin
            if (mem_en[m]) begin
                if (mem_we[m]) bmem[m][mem_addr[m]] <= mem_wdata[m];
                else           mem_rdata[m]        <= bmem[m][mem_addr[m]];
            end
        end
    end

    function automatic logic [DW-1:0] init_word(int m, int a);
        return DW'(m * 4096 + a * 3);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_all();
        req_valid = '0; req_lock = '0; req_we = '0;
        req_mod = '0; req_addr = '0; req_wdata = '0;
    endtask

    task automatic set_req(input int p, input int m, input bit we, input bit lk,
                           input int a, input logic [DW-1:0] d);
        req_valid[p] = 1'b1;
        req_mod[p]   = IW'(m);
        req_we[p]    = we;
        req_lock[p]  = lk;
        req_addr[p]  = AW'(a);
        req_wdata[p] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        clr_all();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive at the falling edge, sample 2 time units later
    task automatic next_step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        #2;
        check(gnt == '0,       "R1 gnt",       32'(gnt), 0);
        check(rsp_valid == '0, "R1 rsp_valid", 32'(rsp_valid), 0);
        check(mem_en == '0,    "R1 mem_en",    32'(mem_en), 0);
    endtask

    task automatic t_parallel();
        do_reset();
        set_req(0, 2, 1, 0, 7, 16'hA0A0);
        set_req(1, 3, 1, 0, 1, 16'hB1B1);
        set_req(2, 0, 1, 0, 2, 16'hC2C2);
        set_req(3, 1, 1, 0, 3, 16'hD3D3);
        #2;
        check(gnt == 4'hF,               "R2 all granted",   32'(gnt), 32'hF);
        check(mem_en == 4'hF,            "R2 all modules",   32'(mem_en), 32'hF);
        check(mem_addr[2] == 8'd7,       "R2 addr routing",  32'(mem_addr[2]), 7);
        check(mem_wdata[3] == 16'hB1B1,  "R2 data routing",  32'(mem_wdata[3]), 32'hB1B1);
        check(mem_we == 4'hF,            "R8 write flag",    32'(mem_we), 32'hF);
        next_step();
        clr_all();
        set_req(0, 2, 0, 0, 7, 0);
        set_req(1, 3, 0, 0, 1, 0);
        set_req(2, 0, 0, 0, 2, 0);
        set_req(3, 1, 0, 0, 3, 0);
        #2;
        check(rsp_valid == '0,           "R8 no return",     32'(rsp_valid), 0);
        check(gnt == 4'hF,               "R2 parallel read", 32'(gnt), 32'hF);
        next_step();
        clr_all();
        #2;
        check(rsp_valid == 4'hF,         "R7 all returned",  32'(rsp_valid), 32'hF);
        check(rsp_data[0] == 16'hA0A0,   "R7 data p0",       32'(rsp_data[0]), 32'hA0A0);
        check(rsp_data[1] == 16'hB1B1,   "R7 data p1",       32'(rsp_data[1]), 32'hB1B1);
        check(rsp_data[2] == 16'hC2C2,   "R7 data p2",       32'(rsp_data[2]), 32'hC2C2);
        check(rsp_data[3] == 16'hD3D3,   "R7 data p3",       32'(rsp_data[3]), 32'hD3D3);
    endtask

    task automatic t_contend();
        do_reset();
        set_req(0, 1, 0, 0, 5, 0);
        set_req(2, 1, 0, 0, 9, 0);
        #2;
        check(gnt == 4'b0001,            "R3 R4 p0 wins",    32'(gnt), 32'b0001);
        check(mem_addr[1] == 8'd5,       "R6 loser hidden",  32'(mem_addr[1]), 5);
        next_step();
        set_req(0, 1, 0, 0, 6, 0);
        #2;
        check(gnt == 4'b0100,            "R4 deferred wins", 32'(gnt), 32'b0100);
        check(rsp_valid == 4'b0001,      "R7 only owner",    32'(rsp_valid), 32'b0001);
        check(rsp_data[0] == init_word(1, 5), "R7 data",     32'(rsp_data[0]),
              32'(init_word(1, 5)));
        next_step();
        clr_all();
        #2;
        check(rsp_valid == 4'b0100,      "R7 deferred data", 32'(rsp_valid), 32'b0100);
        check(rsp_data[2] == init_word(1, 9), "R7 data p2",  32'(rsp_data[2]),
              32'(init_word(1, 9)));
    endtask

    task automatic t_rotate();
        logic [N-1:0] exp_seq [3];
        exp_seq[0] = 4'b0010; exp_seq[1] = 4'b0100; exp_seq[2] = 4'b1000;
        do_reset();
        for (int k = 0; k < 3; k++) begin
            set_req(1, 3, 1, 0, 20, 16'h1111);
            set_req(2, 3, 1, 0, 21, 16'h2222);
            set_req(3, 3, 1, 0, 22, 16'h3333);
            #2;
            check(gnt == exp_seq[k], "R4 rotation order", 32'(gnt), 32'(exp_seq[k]));
            next_step();
        end
        clr_all();
    endtask

    task automatic t_lock();
        do_reset();
        set_req(3, 0, 1, 1, 10, 16'h0101);
        #2;
        check(gnt == 4'b1000,            "R5 first beat",     32'(gnt), 32'b1000);
        next_step();
        set_req(3, 0, 1, 1, 11, 16'h0202);
        set_req(1, 0, 0, 0, 4, 0);
        #2;
        check(gnt == 4'b1000,            "R5 held vs p1",     32'(gnt), 32'b1000);
        check(mem_addr[0] == 8'd11,      "R6 stalled hidden", 32'(mem_addr[0]), 11);
        next_step();
        set_req(3, 0, 1, 0, 12, 16'h0303);
        #2;
        check(gnt == 4'b1000,            "R5 unlock beat",    32'(gnt), 32'b1000);
        next_step();
        set_req(3, 0, 1, 0, 13, 16'h0404);
        #2;
        check(gnt == 4'b0010,            "R5 released",       32'(gnt), 32'b0010);
        next_step();
        clr_all();
        #2;
        check(rsp_valid == 4'b0010,      "R7 after hold",     32'(rsp_valid), 32'b0010);
        check(rsp_data[1] == init_word(0, 4), "R7 data p1",   32'(rsp_data[1]),
              32'(init_word(0, 4)));
        check(bmem[0][12] == 16'h0303,   "R8 locked write",   32'(bmem[0][12]), 32'h0303);
    endtask

    task automatic t_invalid();
        do_reset();
        req_mod[2]  = 2'd0;
        req_addr[2] = 8'd9;
        req_we[2]   = 1'b1;
        req_lock[2] = 1'b1;
        #2;
        check(gnt == '0,    "R9 no grant",  32'(gnt), 0);
        check(mem_en == '0, "R9 no access", 32'(mem_en), 0);
        next_step();
        set_req(0, 0, 0, 0, 3, 0);
        req_valid[2] = 1'b0;
        #2;
        check(gnt == 4'b0001, "R9 no hold left", 32'(gnt), 32'b0001);
        next_step();
        clr_all();
    endtask

    initial begin
        rst = 1'b1;
        clr_all();
        t_reset();
        t_parallel();
        t_contend();
        t_rotate();
        t_lock();
        t_invalid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule